// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block sits beside a small CPU core and decides when the core must stop its normal flow to service an event. Five event sources feed it: vertical blank, display status, timer overflow, serial completion and a four-line joypad. The first four arrive as single-cycle request pulses. The joypad arrives as four raw input lines, and the block watches them for a falling edge. Each event is latched into a pending flag. A flag is raised whether or not that source is enabled and whether or not interrupts are globally allowed. A request goes out only when the master enable is on and at least one pending flag has its enable bit set.

When a request is active, the block presents the vector address of the winning source. The vector is formed as a base of 0x40 plus eight times the source index. The core signals that it has taken the interrupt with an acknowledge strobe. That strobe clears the serviced flag bit and the master enable in the same edge.

The core reports each retired instruction and tells the block whether it was an enable-interrupts or a disable-interrupts instruction. An enable is armed when it retires. It takes effect only when the next ordinary instruction retires. A disable takes effect at once and also cancels an armed enable. Software reads and writes the enable and flag registers through a small select/data port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the flag register reads 0xE0, the master enable is off and irq_req_o is low.
- R2: With reg_sel_i = 0 the port accesses the enable register and with reg_sel_i = 1 the flag register. Bits 4..0 of each are stored in both registers. Bit k maps to source k: 0 vertical blank, 1 display status, 2 timer, 3 serial, 4 joypad. Bits 7..5 read 0 in the enable register and 1 in the flag register.
- R3: A pulse on hw_req_i[k] (k = 0..3) sets flag bit k at that clock edge, whatever the master enable and enable bits hold.
- R4: Flag bit 4 is set when any pad_lines_i bit changes from 1 to 0 between consecutive clock edges. A rising line sets nothing. The lines count as high at reset.
- R5: irq_req_o is high exactly when the master enable is on and the bitwise AND of the enable and flag registers is nonzero. A flag held while disabled is requested once enabling allows it.
- R6: Among enabled pending sources, the lowest-numbered one wins, and irq_vec_o = 0x40 + 8*k (0x40, 0x48, 0x50, 0x58, 0x60).
- R7: When an enable-interrupts instruction retires (retire_i with is_ei_i), the master enable stays off. It turns on when the next retirement that is neither enable nor disable occurs.
- R8: When a disable-interrupts instruction retires, the master enable turns off and any armed enable is dropped. An enable followed directly by a disable therefore admits no request.
- R9: irq_ack_i while irq_req_o is high clears the winning flag bit and the master enable at that edge. Other flag bits are kept.
- R10: irq_ack_i while irq_req_o is low changes neither flags nor master enable.
- R11: When software writes the flag register in the same cycle as a hardware request, the requested bit ends up set. The other bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_req_i | input | 4 | Request pulses: vertical blank, display status, timer overflow, serial |
| pad_lines_i | input | 4 | Joypad input lines, idle high |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 enable, 1 flag |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| retire_i | input | 1 | An instruction retires this cycle |
| is_ei_i | input | 1 | The retiring instruction is enable-interrupts |
| is_di_i | input | 1 | The retiring instruction is disable-interrupts |
| irq_req_o | output | 1 | Interrupt dispatch request |
| irq_vec_o | output | 8 | Vector address of the winning source |
| irq_ack_i | input | 1 | Core has taken the interrupt |

## Verification
Two of the block's functions can land on the same flag bit in one cycle: a software write to the flag register and a hardware request. The bench provokes this by driving a flag write and a hardware pulse in the same cycle, with written values that both clear and keep neighbouring bits. It then reads the flag register back and expects the requested bit to be set and the rest to hold the written value. The enable pipeline is also probed in the cycle where an armed enable meets a disable, and the bench expects no request to appear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC  = 5;
  localparam int HW_SRC   = NUM_SRC - 1;
  localparam int PAD_SRC  = NUM_SRC - 1;
  localparam logic [7:0] VEC_BASE = 8'h40;
  localparam int VEC_STEP = 8;

  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_FLAG   = 1'b1
  } regsel_e;
endpackage

// File: rtl/irqc_fall_detect.sv
module irqc_fall_detect #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lines_i,
  output logic         fall_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = lines_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= prev_d;
  end

  // A line that was high at the last edge and is low now has fallen.
  assign fall_o = |(prev_q & ~lines_i);
endmodule

// File: rtl/irqc_prio_sel.sv
module irqc_prio_sel #(
  parameter int N  = 5,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_chain
    assign grant_o[k]  = req_i[k] & ~seen[k];
    assign seen[k+1]   = seen[k] | req_i[k];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IW'(k);
    end
  end
endmodule

// File: rtl/irqc_master_en.sv
module irqc_master_en (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic retire_i,
  input  logic is_ei_i,
  input  logic is_di_i,
  input  logic take_i,
  output logic ime_o
);
  logic ime_q, ime_d;
  logic arm_q, arm_d;
  logic upd_en;

  assign upd_en = take_i | retire_i;

  always_comb begin
    ime_d = ime_q;
    arm_d = arm_q;
    if (take_i) begin
      ime_d = 1'b0;
      arm_d = 1'b0;
    end else if (retire_i) begin
      if (is_di_i) begin
        ime_d = 1'b0;
        arm_d = 1'b0;
      end else if (is_ei_i) begin
        arm_d = 1'b1;
      end else if (arm_q) begin
        ime_d = 1'b1;
        arm_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ime_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (upd_en) begin
      ime_q <= ime_d;
      arm_q <= arm_d;
    end
  end

  assign ime_o = ime_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int PAD_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HW_SRC-1:0] hw_req_i,
  input  logic [PAD_W-1:0]  pad_lines_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              retire_i,
  input  logic              is_ei_i,
  input  logic              is_di_i,
  output logic              irq_req_o,
  output logic [DATA_W-1:0] irq_vec_o,
  input  logic              irq_ack_i
);
  localparam int IW      = $clog2(NUM_SRC);
  localparam int STEP_SH = $clog2(VEC_STEP);
  localparam int PAD_W_U = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] ie_q, ie_d;
  logic [NUM_SRC-1:0] flag_q, flag_d;
  logic [NUM_SRC-1:0] set_vec, clr_vec, pend, grant;
  logic [IW-1:0]      win_idx;
  logic               any_pend, pad_fall, ime_q, take;
  logic               ie_wr, flag_wr;

  irqc_fall_detect #(.W(PAD_W)) u_pad (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i (pad_lines_i),
    .fall_o  (pad_fall)
  );

  assign pend = ie_q & flag_q;

  irqc_prio_sel #(.N(NUM_SRC), .IW(IW)) u_prio (
    .req_i   (pend),
    .any_o   (any_pend),
    .grant_o (grant),
    .idx_o   (win_idx)
  );

  assign irq_req_o = ime_q & any_pend;
  assign take      = irq_ack_i & irq_req_o;

  irqc_master_en u_ime (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .retire_i (retire_i),
    .is_ei_i  (is_ei_i),
    .is_di_i  (is_di_i),
    .take_i   (take),
    .ime_o    (ime_q)
  );

  assign ie_wr   = reg_we_i & (regsel_e'(reg_sel_i) == SEL_ENABLE);
  assign flag_wr = reg_we_i & (regsel_e'(reg_sel_i) == SEL_FLAG);
  assign set_vec = {pad_fall, hw_req_i};
  assign clr_vec = take ? grant : '0;

  always_comb begin
    ie_d = ie_wr ? reg_wdata_i[NUM_SRC-1:0] : ie_q;
    if (flag_wr) flag_d = reg_wdata_i[NUM_SRC-1:0];
    else         flag_d = flag_q & ~clr_vec;
    // Hardware requests override both software writes and acknowledge.
    flag_d = flag_d | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= '0;
      flag_q <= '0;
    end else begin
      if (ie_wr) ie_q <= ie_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    if (regsel_e'(reg_sel_i) == SEL_FLAG) reg_rdata_o = {{PAD_W_U{1'b1}}, flag_q};
    else                                  reg_rdata_o = {{PAD_W_U{1'b0}}, ie_q};
  end

  assign irq_vec_o = DATA_W'(VEC_BASE) + (DATA_W'(win_idx) << STEP_SH);
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] hw_req_i,
  input logic [3:0] pad_lines_i,
  input logic       reg_we_i,
  input logic       retire_i,
  input logic       is_ei_i,
  input logic       is_di_i,
  input logic       irq_ack_i,
  input logic       irq_req_o,
  input logic [7:0] irq_vec_o,
  input logic [4:0] flag_q,
  input logic       ime_q
);
  assert_hw_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_req_i) |=> ((flag_q[3:0] & $past(hw_req_i)) == $past(hw_req_i)));

  assert_pad_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(pad_lines_i) & ~pad_lines_i)) |=> flag_q[4]);

  assert_vec_grid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_vec_o[2:0] == 3'b000 && irq_vec_o >= 8'h40 && irq_vec_o <= 8'h60));

  assert_ei_delay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && is_ei_i && !is_di_i && !ime_q) |=> !ime_q);

  assert_di_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && is_di_i) |=> !ime_q);

  assert_ack_ime_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o) |=> (!ime_q && !irq_req_o));

  assert_ack_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o && !reg_we_i && hw_req_i == 4'b0 && irq_vec_o == 8'h40) |=> !flag_q[0]);
endmodule

bind irq_vector_ctrl irqc_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hw_req_i    (hw_req_i),
  .pad_lines_i (pad_lines_i),
  .reg_we_i    (reg_we_i),
  .retire_i    (retire_i),
  .is_ei_i     (is_ei_i),
  .is_di_i     (is_di_i),
  .irq_ack_i   (irq_ack_i),
  .irq_req_o   (irq_req_o),
  .irq_vec_o   (irq_vec_o),
  .flag_q      (flag_q),
  .ime_q       (ime_q)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] hw_req = '0;
  logic [3:0] pad = 4'hF;
  logic       we = 1'b0;
  logic       sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       retire = 1'b0, is_ei = 1'b0, is_di = 1'b0;
  logic       req;
  logic [7:0] vec;
  logic       ack = 1'b0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .pad_lines_i(pad),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .retire_i(retire), .is_ei_i(is_ei), .is_di_i(is_di),
    .irq_req_o(req), .irq_vec_o(vec), .irq_ack_i(ack)
  );

  // entry: {ie[4:0], flag[4:0], exp_req, exp_vec[7:0]}
  localparam int NV = 9;
  localparam logic [18:0] VT [NV] = '{
    {5'h1F, 5'h00, 1'b0, 8'h00},
    {5'h1F, 5'h1F, 1'b1, 8'h40},
    {5'h1F, 5'h1E, 1'b1, 8'h48},
    {5'h1F, 5'h1C, 1'b1, 8'h50},
    {5'h1F, 5'h18, 1'b1, 8'h58},
    {5'h1F, 5'h10, 1'b1, 8'h60},
    {5'h0A, 5'h15, 1'b0, 8'h00},
    {5'h0C, 5'h1E, 1'b1, 8'h50},
    {5'h10, 5'h11, 1'b1, 8'h60}
  };

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic s, input logic [7:0] exp, input string tag);
    sel = s;
    #1;
    chk(rdata, exp, tag);
  endtask

  task automatic ret(input logic e, input logic d);
    retire = 1'b1; is_ei = e; is_di = d;
    @(negedge clk);
    retire = 1'b0; is_ei = 1'b0; is_di = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] v);
    hw_req = v;
    @(negedge clk);
    hw_req = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk(1'b0, 8'h00, "R1 enable after reset");
    rd_chk(1'b1, 8'hE0, "R1 flag after reset");
    chk(req, 0, "R1 no request after reset");

    // turn master enable on, then walk the priority table (R5, R6)
    ret(1'b1, 1'b0);
    ret(1'b0, 1'b0);
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, {3'b000, VT[i][18:14]});
      wr(1'b1, {3'b000, VT[i][13:9]});
      chk(req, VT[i][8], $sformatf("R5 request entry %0d", i));
      if (VT[i][8]) chk(vec, VT[i][7:0], $sformatf("R6 vector entry %0d", i));
    end
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    ret(1'b0, 1'b1);

    // R3 flags latch while disabled
    pulse(4'b0110);
    rd_chk(1'b1, 8'hE6, "R3 flags set while disabled");
    wr(1'b0, 8'h06);
    chk(req, 0, "R5 master enable off blocks request");

    // R7 delayed enable
    ret(1'b1, 1'b0);
    chk(req, 0, "R7 no request right after enable retires");
    ret(1'b0, 1'b0);
    chk(req, 1, "R7 request after following instruction");
    chk(vec, 8'h48, "R6 lower source wins");

    // R9 acknowledge
    do_ack();
    rd_chk(1'b1, 8'hE4, "R9 ack clears only serviced flag");
    chk(req, 0, "R9 ack drops master enable");

    // R8 enable then disable
    ret(1'b1, 1'b0);
    ret(1'b0, 1'b1);
    chk(req, 0, "R8 enable then disable admits nothing");
    ret(1'b0, 1'b0);
    chk(req, 0, "R8 armed enable cancelled");

    // R10 ack without request
    do_ack();
    rd_chk(1'b1, 8'hE4, "R10 ack without request keeps flags");
    ret(1'b1, 1'b0);
    ret(1'b0, 1'b0);
    chk(req, 1, "R10 pending flag then requested");
    chk(vec, 8'h50, "R6 timer vector");

    // R11 write and hardware set in the same cycle
    hw_req = 4'b0001;
    wr(1'b1, 8'h00);
    hw_req = '0;
    rd_chk(1'b1, 8'hE1, "R11 set wins over written zero");
    hw_req = 4'b0001;
    wr(1'b1, 8'h02);
    hw_req = '0;
    rd_chk(1'b1, 8'hE3, "R11 written bits kept beside set");

    // R4 joypad edges
    wr(1'b1, 8'h00);
    pad = 4'b1011;
    @(negedge clk);
    rd_chk(1'b1, 8'hF0, "R4 falling line sets joypad flag");
    wr(1'b1, 8'h00);
    pad = 4'b1111;
    @(negedge clk);
    rd_chk(1'b1, 8'hE0, "R4 rising line sets nothing");
    pad = 4'b1110;
    @(negedge clk);
    rd_chk(1'b1, 8'hF0, "R4 another line falls");

    // R2 register widths and fill bits
    wr(1'b0, 8'hFF);
    rd_chk(1'b0, 8'h1F, "R2 enable upper bits read zero");
    wr(1'b1, 8'hFF);
    rd_chk(1'b1, 8'hFF, "R2 flag full write");
    wr(1'b1, 8'h00);
    rd_chk(1'b1, 8'hE0, "R2 flag upper bits read one");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule